// File: doc/BRIEF.md
# Path-Length-Selecting Conditional Branch Predictor

This block predicts the direction of a conditional branch in two table lookups. A path-hash front end supplies one candidate counter-table index for each supported path length. The block first looks up a small selector table with low fetch-address bits to guess which path length the branch uses. That guessed selector then picks one candidate index, and the picked index reads a table of 2-bit saturating counters. The result is the direction guess. Each lookup is registered, so the guess appears two cycles after the fetch.

The true selector travels in the branch opcode and reaches the block at decode. If it differs from the guessed selector, the block reads the counter table again. This second read uses the decoded selector's candidate from the same fetch, and the block flags the new result as a re-prediction. When the branch retires, the block writes the true selector into the selector table. It also moves the counter that the branch used one step toward the actual outcome.

Top module: `bpv_top`

## Requirements
- R1: The selector table has 2^SELT_AW entries and is indexed by fetch_pc[SELT_AW+1:2]; the two lowest address bits are ignored. After reset, every entry holds DEFAULT_SEL.
- R2: After reset, every counter holds 1 (weakly not taken). A counter value of 2 or 3 predicts taken, and 0 or 1 predicts not taken.
- R3: A fetch presented in cycle t raises pred_valid in cycle t+2. In that cycle, pred_sel is the selector-table entry for the fetch address and pred_taken is the guess. A fetch with no decode mismatch leaves redo low.
- R4: The counter read for a fetch uses the candidate slot numbered pred_sel. Slot i occupies cand_vec[i*IDX_W +: IDX_W], and the block captures cand_vec in the fetch cycle.
- R5: If dec_valid is high and dec_sel differs from pred_sel, the block raises both pred_valid and redo in the next cycle. pred_taken then comes from the counter at candidate slot dec_sel of the latest fetch.
- R6: If dec_valid is high and dec_sel equals pred_sel, the block raises neither pred_valid nor redo in the next cycle.
- R7: A retire writes ret_sel into the selector-table entry at ret_pc[SELT_AW+1:2]. Later fetches of that entry report ret_sel.
- R8: A retire changes counter ret_idx by +1 when ret_taken is high and by -1 when it is low. The counter saturates at 3 and at 0.
- R9: If a retire writes a table entry in the same cycle that a lookup reads it, the lookup returns the value from before the write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch of a conditional branch |
| fetch_pc | input | PC_W | Branch address at fetch |
| cand_vec | input | NSEL*IDX_W | Candidate counter indices, one per path length |
| dec_valid | input | 1 | Decode of the latest fetched branch |
| dec_sel | input | SEL_W | Selector carried in the opcode |
| ret_valid | input | 1 | Retirement of a branch |
| ret_pc | input | PC_W | Address of the retiring branch |
| ret_sel | input | SEL_W | True selector of the retiring branch |
| ret_idx | input | IDX_W | Counter index the retiring branch used |
| ret_taken | input | 1 | Actual outcome of the retiring branch |
| pred_valid | output | 1 | A prediction is presented this cycle |
| pred_taken | output | 1 | Predicted direction |
| pred_sel | output | SEL_W | Selector guessed by the selector table |
| redo | output | 1 | The prediction is a re-prediction after a decode mismatch |

## Verification
Two situations are hard to reach from the ports: a retire and a lookup that land on the same entry in the same cycle, and a counter driven against either rail. The stimulus reaches the first by starting a fetch and then driving the retire for that fetch's counter (or selector entry) on exactly the edge that performs the read. The bench then fetches again to confirm that the write took effect. For the rails, the bench retires a run of outcomes in one direction against a single index and then retires one outcome the other way. A counter that wrapped instead of saturating would then give the opposite direction at the next fetch, so the fault shows up at the outputs.

// File: rtl/bpv_pkg.sv
package bpv_pkg;
  // saturating 2-bit step toward the observed outcome
  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
    logic [1:0] nxt;
    if (taken) nxt = (cur == 2'd3) ? 2'd3 : cur + 2'd1;
    else       nxt = (cur == 2'd0) ? 2'd0 : cur - 2'd1;
    return nxt;
  endfunction

  function automatic logic ctr_taken(input logic [1:0] cur);
    return cur[1];
  endfunction
endpackage

// File: rtl/bpv_sel_table.sv
module bpv_sel_table #(
  parameter int AW      = 3,
  parameter int SEL_W   = 2,
  parameter int DEF_SEL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [SEL_W-1:0] rd_q,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [SEL_W-1:0] wr_sel
);
  localparam int DEPTH = 1 << AW;
  logic [SEL_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= SEL_W'(DEF_SEL);
      rd_q <= '0;
    end else begin
      if (rd_en) rd_q <= mem[rd_addr];   // old value on a same-edge write
      if (wr_en) mem[wr_addr] <= wr_sel;
    end
  end
endmodule

// File: rtl/bpv_ctr_table.sv
module bpv_ctr_table
  import bpv_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_q,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken,
  output logic [1:0]       upd_old,
  output logic [1:0]       upd_new
);
  localparam int DEPTH = 1 << IDX_W;
  logic [1:0] mem [DEPTH];

  assign upd_old = mem[upd_idx];
  assign upd_new = ctr_step(upd_old, upd_taken);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 2'd1;
      rd_q <= 2'd1;
    end else begin
      if (rd_en)  rd_q <= mem[rd_idx];
      if (upd_en) mem[upd_idx] <= upd_new;
    end
  end
endmodule

// File: rtl/bpv_cand_mux.sv
module bpv_cand_mux #(
  parameter int SEL_W = 2,
  parameter int IDX_W = 5
) (
  input  logic [(1<<SEL_W)*IDX_W-1:0] cand,
  input  logic [SEL_W-1:0]            sel,
  output logic [IDX_W-1:0]            idx
);
  localparam int NSEL = 1 << SEL_W;
  logic [IDX_W-1:0] slot [NSEL];

  for (genvar g = 0; g < NSEL; g++) begin : g_slot
    assign slot[g] = cand[g*IDX_W +: IDX_W];
  end

  assign idx = slot[sel];
endmodule

// File: rtl/bpv_top.sv
module bpv_top #(
  parameter int PC_W    = 16,
  parameter int SEL_W   = 2,
  parameter int IDX_W   = 5,
  parameter int SELT_AW = 3,
  parameter int DEFAULT_SEL = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fetch_valid,
  input  logic [PC_W-1:0]             fetch_pc,
  input  logic [(1<<SEL_W)*IDX_W-1:0] cand_vec,
  input  logic                        dec_valid,
  input  logic [SEL_W-1:0]            dec_sel,
  input  logic                        ret_valid,
  input  logic [PC_W-1:0]             ret_pc,
  input  logic [SEL_W-1:0]            ret_sel,
  input  logic [IDX_W-1:0]            ret_idx,
  input  logic                        ret_taken,
  output logic                        pred_valid,
  output logic                        pred_taken,
  output logic [SEL_W-1:0]            pred_sel,
  output logic                        redo
);
  import bpv_pkg::*;
  localparam int NSEL   = 1 << SEL_W;
  localparam int CAND_W = NSEL * IDX_W;

  // stage 1 state
  logic              s1_v;
  logic [CAND_W-1:0] cand_q;
  logic [SEL_W-1:0]  s1_sel;
  // stage 2 / output state
  logic              pv_q, redo_q;
  logic [SEL_W-1:0]  held_sel;
  logic [1:0]        ctr_rd;

  // named internal events
  logic              redo_req;
  logic [SEL_W-1:0]  look_sel;
  logic [IDX_W-1:0]  look_idx;
  logic [1:0]        upd_old, upd_new;

  assign redo_req = dec_valid && (dec_sel != held_sel);
  assign look_sel = redo_req ? dec_sel : s1_sel;

  bpv_sel_table #(.AW(SELT_AW), .SEL_W(SEL_W), .DEF_SEL(DEFAULT_SEL)) u_selt (
    .clk(clk), .rst_n(rst_n),
    .rd_en(fetch_valid), .rd_addr(fetch_pc[SELT_AW+1:2]), .rd_q(s1_sel),
    .wr_en(ret_valid), .wr_addr(ret_pc[SELT_AW+1:2]), .wr_sel(ret_sel)
  );

  bpv_cand_mux #(.SEL_W(SEL_W), .IDX_W(IDX_W)) u_mux (
    .cand(cand_q), .sel(look_sel), .idx(look_idx)
  );

  bpv_ctr_table #(.IDX_W(IDX_W)) u_ctr (
    .clk(clk), .rst_n(rst_n),
    .rd_en(s1_v || redo_req), .rd_idx(look_idx), .rd_q(ctr_rd),
    .upd_en(ret_valid), .upd_idx(ret_idx), .upd_taken(ret_taken),
    .upd_old(upd_old), .upd_new(upd_new)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v     <= 1'b0;
      cand_q   <= '0;
      pv_q     <= 1'b0;
      redo_q   <= 1'b0;
      held_sel <= SEL_W'(DEFAULT_SEL);
    end else begin
      s1_v   <= fetch_valid;
      if (fetch_valid) cand_q <= cand_vec;
      pv_q   <= s1_v || redo_req;
      redo_q <= redo_req;
      if (s1_v) held_sel <= s1_sel;
    end
  end

  assign pred_valid = pv_q;
  assign pred_taken = ctr_taken(ctr_rd);
  assign pred_sel   = held_sel;
  assign redo       = redo_q;
endmodule

// File: rtl/bpv_checker.sv
module bpv_checker #(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_valid,
  input logic             dec_valid,
  input logic [SEL_W-1:0] dec_sel,
  input logic [SEL_W-1:0] pred_sel,
  input logic             pred_valid,
  input logic             redo,
  input logic             ret_valid,
  input logic             ret_taken,
  input logic [1:0]       upd_old,
  input logic [1:0]       upd_new
);
  a_r3_two_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> ##2 pred_valid);

  a_r5_redo_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_sel != pred_sel) |=> (pred_valid && redo));

  a_r6_quiet_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_sel == pred_sel) |=> !redo);

  a_r5_redo_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(redo) |-> $past(dec_valid));

  a_r8_hold_top: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_taken && upd_old == 2'd3) |-> upd_new == 2'd3);

  a_r8_hold_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ret_taken && upd_old == 2'd0) |-> upd_new == 2'd0);
endmodule

bind bpv_top bpv_checker #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
  .dec_valid(dec_valid), .dec_sel(dec_sel), .pred_sel(pred_sel),
  .pred_valid(pred_valid), .redo(redo), .ret_valid(ret_valid),
  .ret_taken(ret_taken), .upd_old(upd_old), .upd_new(upd_new)
);

// File: tb/sim_bpv_top.sv
module sim_bpv_top;
  localparam int PC_W = 16, SEL_W = 2, IDX_W = 5, SELT_AW = 3, DEF = 2;
  localparam int NSEL = 1 << SEL_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fetch_valid = 0, dec_valid = 0, ret_valid = 0, ret_taken = 0;
  logic [PC_W-1:0] fetch_pc = '0, ret_pc = '0;
  logic [NSEL*IDX_W-1:0] cand_vec = '0;
  logic [SEL_W-1:0] dec_sel = '0, ret_sel = '0;
  logic [IDX_W-1:0] ret_idx = '0;
  logic pred_valid, pred_taken, redo;
  logic [SEL_W-1:0] pred_sel;

  int checks = 0, failures = 0;
  int ctr_m [1<<IDX_W];
  int sel_m [1<<SELT_AW];

  always #5 clk = ~clk;

  bpv_top #(.PC_W(PC_W), .SEL_W(SEL_W), .IDX_W(IDX_W), .SELT_AW(SELT_AW),
            .DEFAULT_SEL(DEF)) u0 (.*);

  // vector: rpc[41:26] rsel[25:24] ridx[23:19] rtk[18] fpc[17:2] dsel[1:0]
  localparam logic [41:0] VEC [10] = '{
    {16'h0010, 2'd1, 5'd3,  1'b1, 16'h0010, 2'd1},
    {16'h0010, 2'd1, 5'd3,  1'b1, 16'h0013, 2'd0},
    {16'h0024, 2'd3, 5'd7,  1'b1, 16'h0024, 2'd3},
    {16'h0024, 2'd3, 5'd7,  1'b0, 16'h0004, 2'd0},
    {16'h0008, 2'd0, 5'd12, 1'b0, 16'h0008, 2'd2},
    {16'h001C, 2'd2, 5'd30, 1'b1, 16'h001C, 2'd1},
    {16'h001C, 2'd2, 5'd30, 1'b1, 16'h003C, 2'd2},
    {16'h0000, 2'd1, 5'd0,  1'b1, 16'h0000, 2'd3},
    {16'h0014, 2'd0, 5'd3,  1'b1, 16'h0010, 2'd0},
    {16'h0018, 2'd3, 5'd17, 1'b0, 16'h0018, 2'd0}
  };

  function automatic logic [NSEL*IDX_W-1:0] mk_cand(int base, bit same);
    logic [NSEL*IDX_W-1:0] v;
    for (int i = 0; i < NSEL; i++)
      v[i*IDX_W +: IDX_W] = IDX_W'(same ? base : (base ^ (i * 5)));
    return v;
  endfunction

  function automatic int slot_of(logic [NSEL*IDX_W-1:0] v, int s);
    return int'(v[s*IDX_W +: IDX_W]);
  endfunction

  function automatic int model_step(int c, bit tk);
    if (tk) return (c >= 3) ? 3 : c + 1;
    return (c <= 0) ? 0 : c - 1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic retire(int pc, int s, int idx, bit tk);
    @(negedge clk);
    ret_valid = 1; ret_pc = PC_W'(pc); ret_sel = SEL_W'(s);
    ret_idx = IDX_W'(idx); ret_taken = tk;
    @(negedge clk);
    ret_valid = 0;
    sel_m[(pc >> 2) & ((1<<SELT_AW)-1)] = s;
    ctr_m[idx] = model_step(ctr_m[idx], tk);
  endtask

  // fetch and check prediction two edges later (R3/R4 plus caller tag)
  task automatic fetch_chk(int pc, logic [NSEL*IDX_W-1:0] cv, string tag);
    int es, et;
    @(negedge clk);
    fetch_valid = 1; fetch_pc = PC_W'(pc); cand_vec = cv;
    @(negedge clk);
    fetch_valid = 0;
    @(negedge clk);
    es = sel_m[(pc >> 2) & ((1<<SELT_AW)-1)];
    et = (ctr_m[slot_of(cv, es)] >= 2);
    chk(pred_valid && !redo, {"R3 valid ", tag}, {pred_valid, redo}, 2);
    chk(int'(pred_sel) == es, {"R1/R7 sel ", tag}, pred_sel, es);
    chk(int'(pred_taken) == et, {"R4 taken ", tag}, pred_taken, et);
  endtask

  // decode right after a fetch_chk, at the sampling negedge
  task automatic decode_chk(int ds, logic [NSEL*IDX_W-1:0] cv, string tag);
    bit mis;
    int et;
    mis = (ds != int'(pred_sel));
    dec_valid = 1; dec_sel = SEL_W'(ds);
    @(negedge clk);
    dec_valid = 0;
    if (mis) begin
      et = (ctr_m[slot_of(cv, ds)] >= 2);
      chk(pred_valid && redo, {"R5 redo ", tag}, {pred_valid, redo}, 3);
      chk(int'(pred_taken) == et, {"R5 taken ", tag}, pred_taken, et);
    end else begin
      chk(!pred_valid && !redo, {"R6 quiet ", tag}, {pred_valid, redo}, 0);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [NSEL*IDX_W-1:0] cv;
    int e;
    for (int i = 0; i < (1<<IDX_W); i++) ctr_m[i] = 1;
    for (int i = 0; i < (1<<SELT_AW); i++) sel_m[i] = DEF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!pred_valid && !redo, "R3 reset outputs idle", {pred_valid, redo}, 0);

    // R1/R2 reset contents
    cv = mk_cand(5, 0);
    fetch_chk(16'h0020, cv, "reset");
    chk(int'(pred_sel) == DEF, "R1 default selector", pred_sel, DEF);
    chk(pred_taken == 1'b0, "R2 weak not-taken", pred_taken, 0);
    decode_chk(0, cv, "reset");

    // vector table
    for (int v = 0; v < 10; v++) begin
      logic [41:0] w;
      w = VEC[v];
      retire(int'(w[41:26]), int'(w[25:24]), int'(w[23:19]), w[18]);
      cv = mk_cand(int'(w[23:19]), 0);
      fetch_chk(int'(w[17:2]), cv, "vec");
      decode_chk(int'(w[1:0]), cv, "vec");
    end

    // R8 saturation at 3
    cv = mk_cand(20, 1);
    for (int i = 0; i < 5; i++) retire(16'h0040, 3, 20, 1);
    fetch_chk(16'h0040, cv, "R8 top");
    chk(pred_taken == 1'b1, "R8 top taken", pred_taken, 1);
    retire(16'h0040, 3, 20, 0);
    fetch_chk(16'h0040, cv, "R8 top-1");
    chk(pred_taken == 1'b1, "R8 saturated at 3", pred_taken, 1);

    // R8 saturation at 0
    cv = mk_cand(9, 1);
    for (int i = 0; i < 4; i++) retire(16'h0044, 1, 9, 0);
    retire(16'h0044, 1, 9, 1);
    fetch_chk(16'h0044, cv, "R8 bottom+1");
    chk(pred_taken == 1'b0, "R8 saturated at 0", pred_taken, 0);

    // R9 counter write on the same edge as the counter read
    cv = mk_cand(11, 1);
    e = (ctr_m[11] >= 2);
    @(negedge clk);
    fetch_valid = 1; fetch_pc = 16'h0048; cand_vec = cv;
    @(negedge clk);
    fetch_valid = 0;
    ret_valid = 1; ret_pc = 16'h0060; ret_sel = 2'd0; ret_idx = 5'd11; ret_taken = 1;
    @(negedge clk);
    ret_valid = 0;
    chk(int'(pred_taken) == e, "R9 ctr read returns old", pred_taken, e);
    sel_m[(16'h0060 >> 2) & 7] = 0;
    ctr_m[11] = model_step(ctr_m[11], 1);
    fetch_chk(16'h0048, cv, "R9 ctr after");
    chk(pred_taken == 1'b1, "R9 ctr update applied", pred_taken, 1);

    // R9 selector write on the same edge as the selector read
    cv = mk_cand(2, 0);
    e = sel_m[(16'h002C >> 2) & 7];
    @(negedge clk);
    fetch_valid = 1; fetch_pc = 16'h002C; cand_vec = cv;
    ret_valid = 1; ret_pc = 16'h002C; ret_sel = SEL_W'((e + 1) % NSEL);
    ret_idx = 5'd25; ret_taken = 0;
    @(negedge clk);
    fetch_valid = 0; ret_valid = 0;
    @(negedge clk);
    chk(int'(pred_sel) == e, "R9 sel read returns old", pred_sel, e);
    sel_m[(16'h002C >> 2) & 7] = (e + 1) % NSEL;
    ctr_m[25] = model_step(ctr_m[25], 0);
    fetch_chk(16'h002C, cv, "R9 sel after");
    chk(int'(pred_sel) == (e + 1) % NSEL, "R7 sel write applied", pred_sel, (e + 1) % NSEL);

    repeat (2) @(negedge clk);
    report();
  end
endmodule